// File: doc/BRIEF.md
# Dual-Band Field Change Monitor

This block watches two streams of 10-bit converter readings, one taken from a low-frequency antenna path and one from a high-frequency path, to tell when an outside reader switches its field on, off or changes its strength. Each band has its own sample strobe. A start pulse arms the enabled bands. The first valid reading after start becomes both the band's fixed baseline and its last reported level.

Two separate references are kept for each band. The indicator output compares the last reported level with the baseline. It stays on while the band sits more than the threshold away from where it began. The change detector compares every new reading with the last reported level. When the jump is large enough, it emits a one-cycle event that carries the old level, the new level and the number of samples taken since the previous event. The reported level then moves to the new reading. The two bands have separate event outputs, so both can fire in the same cycle.

A mode input, sampled on the start pulse, picks the low band only, the high band only, or both. A stop pulse ends monitoring and clears both indicators.

Each band runs a small state machine with three states. OFF is idle: there are no events and the indicator is low. BASELINE waits for the first valid reading. WATCH compares readings and produces events.

The transitions are as follows:
- Start with the band enabled goes from any state to BASELINE.
- Start with the band disabled goes from any state to OFF.
- A valid reading moves BASELINE to WATCH.
- Stop goes from any state to OFF, and it wins over start.

Top module: `field_change_monitor`

## Requirements
- R1: On a start pulse, each enabled band enters BASELINE. Its first valid reading is taken as both baseline and last reported level, with no event and the indicator off.
- R2: In WATCH, a valid reading whose absolute difference from the last reported level is greater than 10 raises that band's event valid for exactly one cycle, in the cycle after the reading. A difference of exactly 10 raises no event. After an event, the last reported level equals the new reading.
- R3: An event presents the previous reported level on the old output and the triggering reading on the new output.
- R4: The per-band sample counter is cleared at baseline capture and counts every valid reading in WATCH. An event reports the count including its own triggering reading, and then the counter returns to 0.
- R5: The sample counter saturates at 2^CNT_W-1 (255 by default) instead of wrapping.
- R6: A band's indicator is high exactly while the band is in WATCH and the absolute difference between the last reported level and the baseline is greater than 10. It changes in the same cycle as the event that moved the level.
- R7: Mode code 1 enables only the low band. Mode code 2 enables only the high band. Codes 0 and 3 enable both. The disabled band gives no events and keeps its indicator low. The mode is read only on the start pulse, so later changes have no effect until the next start.
- R8: A stop pulse sends both bands to OFF. From the next cycle, indicators are low and no events fire until a new start. Stop wins when start is asserted in the same cycle.
- R9: A reading presented without its band's valid strobe is ignored. It is not counted and it is not compared.
- R10: After reset, both bands are OFF with all event valids and indicators low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Arm pulse; samples mode_i |
| stop_i | input | 1 | End-monitoring pulse |
| mode_i | input | 2 | Band selection code |
| lo_valid_i | input | 1 | Low-band reading strobe |
| lo_data_i | input | 10 | Low-band reading |
| hi_valid_i | input | 1 | High-band reading strobe |
| hi_data_i | input | 10 | High-band reading |
| lo_ind_o | output | 1 | Low-band deviation indicator |
| lo_evt_valid_o | output | 1 | Low-band change event strobe |
| lo_evt_old_o | output | 10 | Low-band previous reported level |
| lo_evt_new_o | output | 10 | Low-band new level |
| lo_evt_cnt_o | output | 8 | Low-band samples since last event |
| hi_ind_o | output | 1 | High-band deviation indicator |
| hi_evt_valid_o | output | 1 | High-band change event strobe |
| hi_evt_old_o | output | 10 | High-band previous reported level |
| hi_evt_new_o | output | 10 | High-band new level |
| hi_evt_cnt_o | output | 8 | High-band samples since last event |

## Verification
The table drives both bands at once. Its steps sit exactly on the threshold, one unit above it, and at both extremes of the reading range in both directions. This separates a strict greater-than comparison from greater-or-equal, and a correct absolute difference from a one-sided subtraction. The table also moves the level back to within 10 of the baseline while still firing an event. That shows whether the indicator follows the baseline reference or the change reference. Directed runs cover the following:
- The selection codes, including a mode change during a run.
- Gaps in the valid strobe, which show whether the counter counts strobes or cycles.
- A long quiet stretch that must stop at the counter's ceiling.
- Stop alone, and stop arriving together with start.

// File: rtl/fcm_pkg.sv
package fcm_pkg;

    typedef enum logic [1:0] {
        S_OFF      = 2'd0,
        S_BASELINE = 2'd1,
        S_WATCH    = 2'd2
    } band_state_t;

    localparam logic [1:0] MODE_LO_ONLY = 2'd1;
    localparam logic [1:0] MODE_HI_ONLY = 2'd2;

endpackage

// File: rtl/fcm_mode_decode.sv
module fcm_mode_decode
    import fcm_pkg::*;
(
    input  logic [1:0] mode_i,
    output logic       lo_en_o,
    output logic       hi_en_o
);

    always_comb begin
        unique case (mode_i)
            MODE_LO_ONLY: begin
                lo_en_o = 1'b1;
                hi_en_o = 1'b0;
            end
            MODE_HI_ONLY: begin
                lo_en_o = 1'b0;
                hi_en_o = 1'b1;
            end
            default: begin
                lo_en_o = 1'b1;
                hi_en_o = 1'b1;
            end
        endcase
    end

endmodule

// File: rtl/fcm_band.sv
module fcm_band
    import fcm_pkg::*;
#(
    parameter int DW     = 10,
    parameter int CW     = 8,
    parameter int THRESH = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    input  logic          en_i,
    input  logic          stop_i,
    input  logic          valid_i,
    input  logic [DW-1:0] data_i,
    output logic          ind_o,
    output logic          evt_valid_o,
    output logic [DW-1:0] evt_old_o,
    output logic [DW-1:0] evt_new_o,
    output logic [CW-1:0] evt_cnt_o
);

    localparam logic [CW-1:0] CNT_MAX = {CW{1'b1}};
    localparam logic [DW-1:0] THR     = DW'(THRESH);

    function automatic logic [DW-1:0] absdiff(input logic [DW-1:0] a, input logic [DW-1:0] b);
        return (a > b) ? (a - b) : (b - a);
    endfunction

    band_state_t   state_q, state_d;
    logic [DW-1:0] base_q, lvl_q;
    logic [CW-1:0] cnt_q;
    logic          take, jump;
    logic [CW-1:0] cnt_inc;

    // a reading counts only when no control pulse overrides it
    assign take    = valid_i && !stop_i && !start_i;
    assign jump    = absdiff(data_i, lvl_q) > THR;
    assign cnt_inc = (cnt_q == CNT_MAX) ? cnt_q : cnt_q + 1'b1;

    // next-state logic
    always_comb begin
        state_d = state_q;
        if (stop_i) begin
            state_d = S_OFF;
        end else if (start_i) begin
            state_d = en_i ? S_BASELINE : S_OFF;
        end else begin
            unique case (state_q)
                S_OFF:      state_d = S_OFF;
                S_BASELINE: if (valid_i) state_d = S_WATCH;
                S_WATCH:    state_d = S_WATCH;
                default:    state_d = S_OFF;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_OFF;
        else        state_q <= state_d;
    end

    // datapath and event outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            base_q      <= '0;
            lvl_q       <= '0;
            cnt_q       <= '0;
            evt_valid_o <= 1'b0;
            evt_old_o   <= '0;
            evt_new_o   <= '0;
            evt_cnt_o   <= '0;
        end else begin
            evt_valid_o <= 1'b0;
            if (take) begin
                unique case (state_q)
                    S_BASELINE: begin
                        base_q <= data_i;
                        lvl_q  <= data_i;
                        cnt_q  <= '0;
                    end
                    S_WATCH: begin
                        if (jump) begin
                            evt_valid_o <= 1'b1;
                            evt_old_o   <= lvl_q;
                            evt_new_o   <= data_i;
                            evt_cnt_o   <= cnt_inc;
                            lvl_q       <= data_i;
                            cnt_q       <= '0;
                        end else begin
                            cnt_q <= cnt_inc;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    assign ind_o = (state_q == S_WATCH) && (absdiff(lvl_q, base_q) > THR);

    // R2: every event spans more than the threshold
    p_evt_beyond_thresh_r2: assert property (@(posedge clk) disable iff (!rst_n)
        evt_valid_o |-> (absdiff(evt_new_o, evt_old_o) > THR));

    // R3: the new level is the reading strobed one cycle earlier
    p_evt_new_is_sample_r3: assert property (@(posedge clk) disable iff (!rst_n)
        evt_valid_o |-> ($past(valid_i) && evt_new_o == $past(data_i)));

    // R8: stop silences indicator and events
    p_stop_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $past(stop_i) |-> (!ind_o && !evt_valid_o));

    // R5: a quiet reading at the ceiling keeps the counter there
    p_cnt_saturates_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_WATCH && take && !jump && cnt_q == CNT_MAX) |=> (cnt_q == CNT_MAX));

    // R4: an event always leaves the counter cleared
    p_cnt_cleared_r4: assert property (@(posedge clk) disable iff (!rst_n)
        evt_valid_o |-> (cnt_q == '0));

endmodule

// File: rtl/field_change_monitor.sv
module field_change_monitor
    import fcm_pkg::*;
#(
    parameter int DW     = 10,
    parameter int CW     = 8,
    parameter int THRESH = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    input  logic          stop_i,
    input  logic [1:0]    mode_i,
    input  logic          lo_valid_i,
    input  logic [DW-1:0] lo_data_i,
    input  logic          hi_valid_i,
    input  logic [DW-1:0] hi_data_i,
    output logic          lo_ind_o,
    output logic          lo_evt_valid_o,
    output logic [DW-1:0] lo_evt_old_o,
    output logic [DW-1:0] lo_evt_new_o,
    output logic [CW-1:0] lo_evt_cnt_o,
    output logic          hi_ind_o,
    output logic          hi_evt_valid_o,
    output logic [DW-1:0] hi_evt_old_o,
    output logic [DW-1:0] hi_evt_new_o,
    output logic [CW-1:0] hi_evt_cnt_o
);

    localparam int NB = 2;

    logic          lo_en, hi_en;
    logic [NB-1:0] en_v, valid_v, ind_v, evt_v;
    logic [DW-1:0] data_v [NB];
    logic [DW-1:0] old_v  [NB];
    logic [DW-1:0] new_v  [NB];
    logic [CW-1:0] cnt_v  [NB];

    fcm_mode_decode u_dec (
        .mode_i  (mode_i),
        .lo_en_o (lo_en),
        .hi_en_o (hi_en)
    );

    assign en_v      = {hi_en, lo_en};
    assign valid_v   = {hi_valid_i, lo_valid_i};
    assign data_v[0] = lo_data_i;
    assign data_v[1] = hi_data_i;

    for (genvar b = 0; b < NB; b++) begin : g_band
        fcm_band #(.DW(DW), .CW(CW), .THRESH(THRESH)) u_band (
            .clk         (clk),
            .rst_n       (rst_n),
            .start_i     (start_i),
            .en_i        (en_v[b]),
            .stop_i      (stop_i),
            .valid_i     (valid_v[b]),
            .data_i      (data_v[b]),
            .ind_o       (ind_v[b]),
            .evt_valid_o (evt_v[b]),
            .evt_old_o   (old_v[b]),
            .evt_new_o   (new_v[b]),
            .evt_cnt_o   (cnt_v[b])
        );
    end

    assign lo_ind_o       = ind_v[0];
    assign lo_evt_valid_o = evt_v[0];
    assign lo_evt_old_o   = old_v[0];
    assign lo_evt_new_o   = new_v[0];
    assign lo_evt_cnt_o   = cnt_v[0];
    assign hi_ind_o       = ind_v[1];
    assign hi_evt_valid_o = evt_v[1];
    assign hi_evt_old_o   = old_v[1];
    assign hi_evt_new_o   = new_v[1];
    assign hi_evt_cnt_o   = cnt_v[1];

    // R7: a start in low-only mode keeps the high band silent next cycle
    p_lo_only_silences_hi_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $past(start_i && !stop_i && mode_i == MODE_LO_ONLY) |-> (!hi_ind_o && !hi_evt_valid_o));

    // R7: a start in high-only mode keeps the low band silent next cycle
    p_hi_only_silences_lo_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $past(start_i && !stop_i && mode_i == MODE_HI_ONLY) |-> (!lo_ind_o && !lo_evt_valid_o));

endmodule

// File: tb/field_change_monitor_bench.sv
module field_change_monitor_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start_i = 1'b0, stop_i = 1'b0;
    logic [1:0] mode_i = 2'd0;
    logic       lo_valid_i = 1'b0, hi_valid_i = 1'b0;
    logic [9:0] lo_data_i = '0, hi_data_i = '0;
    logic       lo_ind_o, lo_evt_valid_o, hi_ind_o, hi_evt_valid_o;
    logic [9:0] lo_evt_old_o, lo_evt_new_o, hi_evt_old_o, hi_evt_new_o;
    logic [7:0] lo_evt_cnt_o, hi_evt_cnt_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    field_change_monitor u_field_change_monitor (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .stop_i(stop_i), .mode_i(mode_i),
        .lo_valid_i(lo_valid_i), .lo_data_i(lo_data_i),
        .hi_valid_i(hi_valid_i), .hi_data_i(hi_data_i),
        .lo_ind_o(lo_ind_o), .lo_evt_valid_o(lo_evt_valid_o), .lo_evt_old_o(lo_evt_old_o),
        .lo_evt_new_o(lo_evt_new_o), .lo_evt_cnt_o(lo_evt_cnt_o),
        .hi_ind_o(hi_ind_o), .hi_evt_valid_o(hi_evt_valid_o), .hi_evt_old_o(hi_evt_old_o),
        .hi_evt_new_o(hi_evt_new_o), .hi_evt_cnt_o(hi_evt_cnt_o)
    );

    typedef struct packed {
        logic [9:0] lo;
        logic [9:0] hi;
        logic       lo_e;
        logic       hi_e;
        logic [7:0] lo_c;
        logic [7:0] hi_c;
        logic       lo_i;
        logic       hi_i;
    } vec_t;

    localparam int NV = 8;
    // step 0 is the baseline capture; both bands strobed every step
    localparam vec_t VECS [NV] = '{
        '{10'd500,  10'd100,  1'b0, 1'b0, 8'd0, 8'd0, 1'b0, 1'b0},
        '{10'd510,  10'd111,  1'b0, 1'b1, 8'd0, 8'd1, 1'b0, 1'b1},
        '{10'd511,  10'd105,  1'b1, 1'b0, 8'd2, 8'd0, 1'b1, 1'b1},
        '{10'd500,  10'd100,  1'b1, 1'b1, 8'd1, 8'd2, 1'b0, 1'b0},
        '{10'd0,    10'd1023, 1'b1, 1'b1, 8'd1, 8'd1, 1'b1, 1'b1},
        '{10'd1023, 10'd0,    1'b1, 1'b1, 8'd1, 8'd1, 1'b1, 1'b1},
        '{10'd1013, 10'd10,   1'b0, 1'b0, 8'd0, 8'd0, 1'b1, 1'b1},
        '{10'd490,  10'd110,  1'b1, 1'b1, 8'd2, 8'd2, 1'b0, 1'b0}
    };

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // drive at negedge, let one posedge register it, check at the next negedge
    task automatic tick();
        @(posedge clk);
        @(negedge clk);
        start_i = 1'b0;
        stop_i = 1'b0;
        lo_valid_i = 1'b0;
        hi_valid_i = 1'b0;
    endtask

    task automatic sample(input logic lv, input logic [9:0] ld, input logic hv, input logic [9:0] hd);
        lo_valid_i = lv; lo_data_i = ld;
        hi_valid_i = hv; hi_data_i = hd;
        tick();
    endtask

    task automatic arm(input logic [1:0] m);
        mode_i = m;
        start_i = 1'b1;
        tick();
    endtask

    task automatic halt();
        stop_i = 1'b1;
        tick();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        logic [9:0] lvl_lo, lvl_hi;
        int quiet_evts;
        lvl_lo = '0;
        lvl_hi = '0;
        repeat (3) @(negedge clk);
        // R10: reset state
        check("R10 lo_ind", lo_ind_o, 0);
        check("R10 hi_ind", hi_ind_o, 0);
        check("R10 evts", {lo_evt_valid_o, hi_evt_valid_o}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        sample(1'b1, 10'd900, 1'b1, 10'd900);
        check("R10 idle no lo evt", lo_evt_valid_o, 0);

        // table walk, both bands enabled (R1 R2 R3 R4 R6)
        arm(2'd0);
        for (int i = 0; i < NV; i++) begin
            sample(1'b1, VECS[i].lo, 1'b1, VECS[i].hi);
            if (i == 0) begin
                lvl_lo = VECS[i].lo;
                lvl_hi = VECS[i].hi;
                check("R1 no evt at baseline", {lo_evt_valid_o, hi_evt_valid_o}, 0);
            end else begin
                check("R2 lo evt", lo_evt_valid_o, VECS[i].lo_e);
                check("R2 hi evt", hi_evt_valid_o, VECS[i].hi_e);
                if (VECS[i].lo_e) begin
                    check("R3 lo old", lo_evt_old_o, lvl_lo);
                    check("R3 lo new", lo_evt_new_o, VECS[i].lo);
                    check("R4 lo cnt", lo_evt_cnt_o, VECS[i].lo_c);
                    lvl_lo = VECS[i].lo;
                end
                if (VECS[i].hi_e) begin
                    check("R3 hi old", hi_evt_old_o, lvl_hi);
                    check("R3 hi new", hi_evt_new_o, VECS[i].hi);
                    check("R4 hi cnt", hi_evt_cnt_o, VECS[i].hi_c);
                    lvl_hi = VECS[i].hi;
                end
            end
            check("R6 lo ind", lo_ind_o, VECS[i].lo_i);
            check("R6 hi ind", hi_ind_o, VECS[i].hi_i);
        end
        @(negedge clk);
        check("R2 single-cycle pulse", {lo_evt_valid_o, hi_evt_valid_o}, 0);

        // R7: low band only; mode change mid-run has no effect
        arm(2'd1);
        sample(1'b1, 10'd200, 1'b1, 10'd200);
        sample(1'b1, 10'd200, 1'b1, 10'd900);
        check("R7 hi ignored in mode 1", hi_evt_valid_o, 0);
        check("R7 hi ind low in mode 1", hi_ind_o, 0);
        mode_i = 2'd2;
        sample(1'b1, 10'd300, 1'b1, 10'd0);
        check("R7 lo still active after mode change", lo_evt_valid_o, 1);
        check("R7 hi still off after mode change", hi_evt_valid_o, 0);

        // R7: high band only
        arm(2'd2);
        sample(1'b1, 10'd0, 1'b1, 10'd400);
        sample(1'b1, 10'd1000, 1'b1, 10'd450);
        check("R7 lo ignored in mode 2", lo_evt_valid_o, 0);
        check("R7 lo ind low in mode 2", lo_ind_o, 0);
        check("R7 hi active in mode 2", hi_evt_valid_o, 1);

        // R7: code 3 enables both
        arm(2'd3);
        sample(1'b1, 10'd100, 1'b1, 10'd100);
        sample(1'b1, 10'd150, 1'b1, 10'd150);
        check("R7 mode 3 lo", lo_evt_valid_o, 1);
        check("R7 mode 3 hi", hi_evt_valid_o, 1);

        // R9: unstrobed readings are neither compared nor counted
        arm(2'd1);
        sample(1'b1, 10'd100, 1'b0, 10'd0);
        sample(1'b0, 10'd900, 1'b0, 10'd0);
        check("R9 no evt without strobe", lo_evt_valid_o, 0);
        sample(1'b0, 10'd900, 1'b0, 10'd0);
        sample(1'b1, 10'd100, 1'b0, 10'd0);
        sample(1'b1, 10'd105, 1'b0, 10'd0);
        sample(1'b1, 10'd200, 1'b0, 10'd0);
        check("R9 evt after gaps", lo_evt_valid_o, 1);
        check("R9 gap cycles not counted", lo_evt_cnt_o, 3);

        // R8: stop clears indicator and silences events
        check("R8 ind on before stop", lo_ind_o, 1);
        halt();
        check("R8 ind off after stop", lo_ind_o, 0);
        sample(1'b1, 10'd900, 1'b1, 10'd900);
        check("R8 no evt after stop", lo_evt_valid_o, 0);
        // R8: stop wins over simultaneous start
        start_i = 1'b1;
        stop_i = 1'b1;
        tick();
        sample(1'b1, 10'd100, 1'b0, 10'd0);
        sample(1'b1, 10'd900, 1'b0, 10'd0);
        check("R8 stop beats start", lo_evt_valid_o, 0);

        // R5: counter saturates at 255
        arm(2'd1);
        sample(1'b1, 10'd300, 1'b0, 10'd0);
        quiet_evts = 0;
        for (int k = 0; k < 300; k++) begin
            sample(1'b1, 10'd300, 1'b0, 10'd0);
            if (lo_evt_valid_o) quiet_evts++;
        end
        check("R5 no evt while quiet", quiet_evts, 0);
        sample(1'b1, 10'd400, 1'b0, 10'd0);
        check("R5 evt after long run", lo_evt_valid_o, 1);
        check("R5 count saturated", lo_evt_cnt_o, 255);
        sample(1'b1, 10'd500, 1'b0, 10'd0);
        check("R4 count restarts after saturated evt", lo_evt_cnt_o, 1);

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule